// File: doc/BRIEF.md
# Scanned Decimal Readout Driver

This block holds an 8-bit result taken from the data bus and presents it as a decimal number on a four-position, time-multiplexed seven-segment display. A load strobe captures the bus value; between strobes the held value is shown unchanged. Only one digit position is lit at any time. A position counter, paced by a prescaler running from the system clock, steps through the positions. A one-hot enable lights the active position. A lookup turns the held value and the active position index into that position's segment pattern.

Positions are ones, tens, hundreds and sign, in that scan order (index 0 to 3). A mode input reads the held value either as unsigned (0 to 255) or as two's complement (-128 to 127). In two's-complement mode a negative value is shown as its magnitude, with a minus bar in the sign position. Leading zeros are dark.

Top module: `dec_display_top`

## Requirements
- R1: While rst_n is low at a clock edge, the held value is cleared to 0 and the position index to 0. Directly after reset, digit_en is 4'b0001 and seg_out is 7'h3F (the digit 0).
- R2: A rising clock edge with load_en high copies bus_data into the held value. With load_en low, the held value, and so the displayed number, does not change whatever bus_data does.
- R3: The position index advances by one every SCAN_DIV clock cycles, in the order 0 ones, 1 tens, 2 hundreds, 3 sign, then back to 0.
- R4: Exactly one bit of digit_en is high at all times, and bit i is the one high while position i is active.
- R5: seg_out is active-high, with bit 0 = segment a through bit 6 = segment g. Digits 0 to 9 use the patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R6: With signed_mode low, the held value is shown as an unsigned decimal number from 0 to 255, and the sign position is dark (7'h00).
- R7: With signed_mode high and bit 7 of the held value set, the number shown is 256 minus the value, and the sign position shows only segment g (7'h40). With bit 7 clear, the value is shown as in R6, and the sign position is dark.
- R8: The hundreds position is dark when the magnitude is below 100. The tens position is dark when the magnitude is below 10. The ones position is always lit, so 0 shows as a single 0.
- R9: In signed mode the held value 8'h80 shows 1, 2, 8 with a minus bar, that is -128.
- R10: signed_mode is not registered. A change on it alters seg_out in the same cycle, without a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Capture strobe for bus_data |
| bus_data | input | 8 | Value offered by the data bus |
| signed_mode | input | 1 | 1 = two's-complement reading, 0 = unsigned |
| seg_out | output | 7 | Segments a..g of the active position, active-high, bit 0 = a |
| digit_en | output | 4 | One-hot position enable, bit 0 = ones, bit 3 = sign |

## Verification
The hardest case to reach from the ports is a particular value being on display at a particular position under a particular mode. The scan is free-running and cannot be steered, so stimulus alone cannot place them together. The bench therefore holds each directed value for a full four-position sweep while it keeps its own model of the scan phase. This covers blanking edges (9/10, 99/100), the 8'h80 extreme and negative values on every position. Random loads and mode flips are also made at arbitrary scan phases, so loads arrive mid-sweep and the live mode input switches the sign position while it is lit.

// File: rtl/dec_disp_pkg.sv
// Shared constants and the digit glyph function for the decimal readout.
// Assumes a seven-segment layout with bit 0 = segment a .. bit 6 = segment g.
package dec_disp_pkg;

    localparam int NUM_POS = 4;
    localparam int POS_W   = 2;
    localparam int SEG_W   = 7;

    typedef enum logic [POS_W-1:0] {
        POS_ONES     = 2'd0,
        POS_TENS     = 2'd1,
        POS_HUNDREDS = 2'd2,
        POS_SIGN     = 2'd3
    } pos_e;

    localparam logic [SEG_W-1:0] SEG_DARK  = 7'h00;
    localparam logic [SEG_W-1:0] SEG_MINUS = 7'h40;

    // Map one decimal digit to its active-high segment pattern.
    function automatic logic [SEG_W-1:0] glyph(input logic [3:0] d);
        logic [SEG_W-1:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = SEG_DARK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dec_value_latch.sv
// Holding register for the value to display.
// Assumes load_en is synchronous to clk; reset is synchronous active-low.
module dec_value_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] value_q
);

    // Capture the bus on a load strobe, otherwise keep the held value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= '0;
        else if (load_en)
            value_q <= bus_data;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_en)) |-> value_q == $past(bus_data));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_en)) |-> $stable(value_q));

endmodule

// File: rtl/dec_scan_timer.sv
// Prescaler and position counter for the multiplexed scan.
// Assumes SCAN_DIV >= 1; the index steps once per SCAN_DIV clocks and wraps.
module dec_scan_timer
    import dec_disp_pkg::*;
#(
    parameter int SCAN_DIV = 25000
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos_idx
);

    localparam int CNT_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SCAN_DIV - 1);

    logic [CNT_W-1:0] pre_cnt;
    logic             step;

    // A step is due on the last count of each prescale period.
    assign step = (pre_cnt == LAST);

    // Prescale counter: counts 0 .. SCAN_DIV-1 and restarts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_cnt <= '0;
        else if (step)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + CNT_W'(1);
    end

    // Position index: advances one position per prescale period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_idx <= '0;
        else if (step)
            pos_idx <= pos_idx + POS_W'(1);
    end

    assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= LAST);

    assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pos_idx != $past(pos_idx))
            |-> pos_idx == $past(pos_idx) + POS_W'(1));

endmodule

// File: rtl/dec_digit_select.sv
// Decoder from position index to one-hot digit enable.
// Assumes NUM_POS equals 2**POS_W so every index maps to one enable.
module dec_digit_select
    import dec_disp_pkg::*;
(
    input  logic [POS_W-1:0]   pos_idx,
    output logic [NUM_POS-1:0] digit_en
);

    // One enable line per position, high only when the index matches.
    for (genvar i = 0; i < NUM_POS; i++) begin : g_en
        assign digit_en[i] = (pos_idx == POS_W'(i));
    end

endmodule

// File: rtl/dec_digit_lookup.sv
// Conversion from held value and position index to the segment pattern.
// Assumes DATA_W <= 9 so the magnitude has at most three decimal digits.
module dec_digit_lookup
    import dec_disp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] value_q,
    input  logic              signed_mode,
    input  logic [POS_W-1:0]  pos_idx,
    output logic [SEG_W-1:0]  seg
);

    logic              negative;
    logic [DATA_W-1:0] mag;
    int unsigned       mag_i;
    logic [3:0]        d_ones, d_tens, d_hund;

    // Magnitude: two's-complement negation for negative signed values.
    always_comb begin
        negative = signed_mode && value_q[DATA_W-1];
        mag      = negative ? (~value_q + DATA_W'(1)) : value_q;
        mag_i    = int'(unsigned'(mag));
        d_ones   = 4'(mag_i % 10);
        d_tens   = 4'((mag_i / 10) % 10);
        d_hund   = 4'(mag_i / 100);
    end

    // Pattern for the active position, with leading zeros dark.
    always_comb begin
        case (pos_e'(pos_idx))
            POS_ONES:     seg = glyph(d_ones);
            POS_TENS:     seg = (mag_i >= 10)  ? glyph(d_tens) : SEG_DARK;
            POS_HUNDREDS: seg = (mag_i >= 100) ? glyph(d_hund) : SEG_DARK;
            default:      seg = negative ? SEG_MINUS : SEG_DARK;
        endcase
    end

endmodule

// File: rtl/dec_display_top.sv
// Scanned decimal readout: held bus value shown on four multiplexed positions.
// Assumes synchronous active-low reset; signed_mode is applied live.
module dec_display_top
    import dec_disp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SCAN_DIV = 25000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [DATA_W-1:0]   bus_data,
    input  logic                signed_mode,
    output logic [SEG_W-1:0]    seg_out,
    output logic [NUM_POS-1:0]  digit_en
);

    logic [DATA_W-1:0] value_q;
    logic [POS_W-1:0]  pos_idx;

    dec_value_latch #(.DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .bus_data (bus_data),
        .value_q  (value_q)
    );

    dec_scan_timer #(.SCAN_DIV(SCAN_DIV)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_idx (pos_idx)
    );

    dec_digit_select u_sel (
        .pos_idx  (pos_idx),
        .digit_en (digit_en)
    );

    dec_digit_lookup #(.DATA_W(DATA_W)) u_lut (
        .value_q     (value_q),
        .signed_mode (signed_mode),
        .pos_idx     (pos_idx),
        .seg         (seg_out)
    );

    assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(digit_en) == 1);

    assert_sign_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_en[NUM_POS-1] && !(signed_mode && value_q[DATA_W-1]))
            |-> seg_out == SEG_DARK);

    assert_hund_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!signed_mode && digit_en[2] && value_q < DATA_W'(100))
            |-> seg_out == SEG_DARK);

endmodule

// File: tb/dec_display_top_tb_top.sv
module dec_display_top_tb_top;

    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       signed_mode = 1'b0;
    logic [6:0] seg_out;
    logic [3:0] digit_en;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    string tag_ovr = "";

    // Bench-side scan and value model.
    int   m_pre = 0;
    int   m_idx = 0;
    logic [7:0] m_val = 8'h00;

    always #2 clk = ~clk;

    dec_display_top #(.DATA_W(8), .SCAN_DIV(DIV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .bus_data    (bus_data),
        .signed_mode (signed_mode),
        .seg_out     (seg_out),
        .digit_en    (digit_en)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    function automatic logic [6:0] exp_seg(input logic [7:0] v, input bit sm, input int pos);
        int mag;
        bit neg;
        neg = sm && v[7];
        mag = neg ? 256 - int'(v) : int'(v);
        case (pos)
            0: return pat(mag % 10);
            1: return (mag >= 10) ? pat((mag / 10) % 10) : 7'h00;
            2: return (mag >= 100) ? pat(mag / 100) : 7'h00;
            default: return neg ? 7'h40 : 7'h00;
        endcase
    endfunction

    function automatic string pick_tag(input logic [7:0] v, input bit sm, input int pos);
        int mag;
        mag = (sm && v[7]) ? 256 - int'(v) : int'(v);
        if (tag_ovr != "") return tag_ovr;
        if (sm && v == 8'h80) return "R9";
        if (pos == 3) return sm ? "R7" : "R6";
        if ((pos == 2 && mag < 100) || (pos == 1 && mag < 10)) return "R8";
        return sm ? "R7" : "R5";
    endfunction

    // Model update at the same edge as the design.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_pre <= 0; m_idx <= 0; m_val <= 8'h00;
        end else begin
            if (load_en) m_val <= bus_data;
            if (m_pre == DIV - 1) begin
                m_pre <= 0; m_idx <= (m_idx + 1) % 4;
            end else begin
                m_pre <= m_pre + 1;
            end
        end
    end

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (checking && !done) begin
            logic [6:0] es;
            logic [3:0] ed;
            string t;
            ed = 4'b0001 << m_idx;
            es = exp_seg(m_val, signed_mode, m_idx);
            t  = pick_tag(m_val, signed_mode, m_idx);
            tests++;
            if (digit_en !== ed) begin
                fails++;
                $display("FAIL %s digit_en: actual %b expected %b (R3/R4)",
                         (tag_ovr != "") ? tag_ovr : "R4", digit_en, ed);
            end
            tests++;
            if (seg_out !== es) begin
                fails++;
                $display("FAIL %s seg_out pos %0d val %h mode %0d: actual %h expected %h",
                         t, m_idx, m_val, signed_mode, seg_out, es);
            end
        end
    end

    task automatic show(input logic [7:0] v, input bit sm);
        @(negedge clk); #1;
        load_en = 1'b1; bus_data = v; signed_mode = sm;
        @(negedge clk); #1;
        load_en = 1'b0; bus_data = $urandom;
        repeat (4 * DIV + 1) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: first cycles after reset show 0 on ones position
        tag_ovr = "R1";
        checking = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 tag_ovr = "";
        repeat (4 * DIV) @(negedge clk);

        // Directed corners in both modes (R5 R6 R7 R8 R9)
        show(8'd0, 1'b0);   show(8'd9, 1'b0);   show(8'd10, 1'b0);
        show(8'd99, 1'b0);  show(8'd100, 1'b0); show(8'd255, 1'b0);
        show(8'd128, 1'b0); show(8'h80, 1'b1);  show(8'hFF, 1'b1);
        show(8'd127, 1'b1); show(8'hF6, 1'b1);  show(8'h9C, 1'b1);
        show(8'hF7, 1'b1);  show(8'd5, 1'b1);

        // R2: load_en low, bus changes must not alter the display
        show(8'd42, 1'b0);
        tag_ovr = "R2";
        for (int k = 0; k < 4 * DIV * 2; k++) begin
            @(negedge clk); #1 bus_data = $urandom;
        end
        tag_ovr = "";

        // R10: live mode flip on a held negative value
        show(8'hB5, 1'b0);
        tag_ovr = "R10";
        for (int k = 0; k < 4 * DIV * 2; k++) begin
            @(negedge clk); #1 signed_mode = ~signed_mode;
        end
        tag_ovr = "";

        // Random loads and mode flips at arbitrary scan phases
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk); #1;
            load_en  = (($urandom % 6) == 0);
            bus_data = $urandom;
            if (($urandom % 25) == 0) signed_mode = ~signed_mode;
        end
        load_en = 1'b0;
        repeat (2) @(negedge clk);

        // R1 again: mid-run reset returns to the zero display
        #1 rst_n = 1'b0; checking = 1'b0;
        @(negedge clk); @(negedge clk);
        #1 rst_n = 1'b1; signed_mode = 1'b0; tag_ovr = "R1"; checking = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 tag_ovr = "";

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule